// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This unit decides whether a branch-conditional instruction that runs over a vector of elements is taken. A `start_i` pulse loads a vector length, a predicate mask, a 5-bit selector, two branch-option bits and a 5-bit mode word. The unit then walks the elements one per clock in ascending order. For each element it reads one 4-bit field from an external condition file through a combinational read port, picks one bit of that field, and tests it against the option bits.

The per-element results are merged as an AND or an OR. The walk stops at the first element that decides the result. When an element is masked out by the predicate, the unit can skip it or test a substitute bit in its place. In the vector-length-setting modes, the first failing element also produces a truncated vector length.

When the walk ends, the unit gives a one-cycle `done_o` pulse. With it come the branch decision and the number of unmasked elements tested, which the caller uses as the loop-counter decrement. The caller sequences the stepping, reordering and program-counter update around this unit.

Top module: `vbr_eval`

## Requirements
- R1: Element i reads condition field (`sel_i[4:2]`*16 + i) mod 128 through `crf_idx_o`. The tested bit is `crf_data_i[sel_i[1:0]]`.
- R2: An element passes when `bo_i[0]` is 1, or when its test bit equals `bo_i[1]`.
- R3: When `mode_i[3]` is 1 (ALL), the merge is an AND that starts at 1. The first failing element ends the walk with `taken_o`=0. If no element fails, `taken_o`=1.
- R4: When `mode_i[3]` is 0 (ANY), the merge is an OR that starts at 0. The first passing element ends the walk with `taken_o`=1. If no element passes, `taken_o`=0.
- R5: Elements are visited in ascending order, one per clock. If the walk ends at element e, `done_o` is high in the (e+2)-th cycle after the cycle in which `start_i` is sampled. Elements after e are never read.
- R6: A masked element (predicate bit 0) with `mode_i[4]`=0 is skipped. It still takes its clock, but it changes neither the result nor the count, and it cannot end the walk early.
- R7: A masked element with `mode_i[4]`=1 is tested with a substitute bit. The substitute is `mode_i[2]` when `mode_i[1:0]` is 0 or 2, and 0 when `mode_i[1:0]` is 1 or 3.
- R8: When `mode_i[1:0]` is 1 or 3, the first tested element that fails ends the walk and drives `vl_update_o`=1. `new_vl_o` is then that element's index plus 1 when `mode_i[2]`=1, and the index itself when `mode_i[2]`=0. If no element fails, `vl_update_o`=0 and `new_vl_o` equals the loaded length.
- R9: `dec_count_o` counts the unmasked elements visited, up to and including the element that ends the walk.
- R10: When the loaded length is 0, `done_o` is high in the cycle after start. `taken_o` is then the inverse of `mode_i[3]` and `dec_count_o` is 0.
- R11: After reset, `done_o`, `taken_o`, `vl_update_o` and `dec_count_o` are 0. `done_o` is a single-cycle pulse. The results hold until the next accepted start.
- R12: A `start_i` that arrives while a walk is in progress is ignored.
- R13: Mode values 2 and 3 in `mode_i[1:0]` evaluate exactly like modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an evaluation (sampled only when idle) |
| vl_i | input | 7 | Vector length, 0 to MAX_VL |
| pred_i | input | 64 | Predicate mask, bit i for element i |
| sel_i | input | 5 | Field-group and bit selector |
| bo_i | input | 2 | [0] force pass, [1] bit value that passes |
| mode_i | input | 5 | [1:0] mode, [2] substitute bit or length-inclusive flag, [3] ALL, [4] substitute enable |
| crf_idx_o | output | 7 | Condition-file field index |
| crf_data_i | input | 4 | Condition-file field read data |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision |
| new_vl_o | output | 7 | Truncated vector length |
| vl_update_o | output | 1 | `new_vl_o` is a truncation |
| dec_count_o | output | 7 | Counter decrement |

## Verification
Every value of the mode word is swept against all four option-bit pairs. The sweep runs with lengths of 0, 1, 5 and 17 elements, over two selectors, one of which wraps past field 127. It uses three predicate masks: all set, all clear and mixed.
- The all-clear mask separates skipping from substitution, including the forced-zero substitute in the length-setting modes.
- The mixed mask exposes any miscount of the decrement or a wrong field index.
- The cycle count from start to `done_o` shows that the walk stopped at the exit element, since a late stop would read further fields.

Two further runs cover a full 64-element walk that wraps the file, and a start pulse that arrives mid-walk.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  typedef enum logic [1:0] {
    MODE_NORM       = 2'd0,
    MODE_VLSET      = 2'd1,
    MODE_STEP       = 2'd2,
    MODE_STEP_VLSET = 2'd3
  } vbr_mode_e;

  typedef struct packed {
    logic vlset;  // truncate VL at first failure
    logic vli;    // truncation includes failing element
    logic subst;  // substitute bit for masked elements
    logic all;    // AND merge
    logic sz;     // test masked elements instead of skipping
  } vbr_ctl_t;
endpackage

// File: rtl/vbr_mode_dec.sv
module vbr_mode_dec
  import vbr_pkg::*;
(
  input  logic [4:0] mode_i,
  output vbr_ctl_t   ctl_o
);
  vbr_mode_e mode;
  assign mode = vbr_mode_e'(mode_i[1:0]);

  always_comb begin
    ctl_o.vlset = (mode == MODE_VLSET) || (mode == MODE_STEP_VLSET);
    // bit 2 is shared: VLI in VL-set modes, substitute bit otherwise
    ctl_o.vli   = ctl_o.vlset & mode_i[2];
    ctl_o.subst = ~ctl_o.vlset & mode_i[2];
    ctl_o.all   = mode_i[3];
    ctl_o.sz    = mode_i[4];
  end
endmodule

// File: rtl/vbr_elem_test.sv
module vbr_elem_test (
  input  logic [3:0] field_i,
  input  logic [1:0] bit_sel_i,
  input  logic       pred_i,
  input  logic       sz_i,
  input  logic       subst_i,
  input  logic [1:0] bo_i,
  output logic       skip_o,
  output logic       ok_o,
  output logic       counted_o
);
  logic test_bit;

  always_comb begin
    test_bit  = pred_i ? field_i[bit_sel_i] : subst_i;
    ok_o      = bo_i[0] | ~(test_bit ^ bo_i[1]);
    skip_o    = ~pred_i & ~sz_i;
    counted_o = pred_i;
  end
endmodule

// File: rtl/vbr_eval.sv
module vbr_eval
  import vbr_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int NFIELDS = 128
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [$clog2(MAX_VL+1)-1:0]       vl_i,
  input  logic [MAX_VL-1:0]                 pred_i,
  input  logic [4:0]                        sel_i,
  input  logic [1:0]                        bo_i,
  input  logic [4:0]                        mode_i,
  output logic [$clog2(NFIELDS)-1:0]        crf_idx_o,
  input  logic [3:0]                        crf_data_i,
  output logic                              done_o,
  output logic                              taken_o,
  output logic [$clog2(MAX_VL+1)-1:0]       new_vl_o,
  output logic                              vl_update_o,
  output logic [$clog2(MAX_VL+1)-1:0]       dec_count_o
);
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int PIW = $clog2(MAX_VL);
  localparam int FW  = $clog2(NFIELDS);

  logic              busy_q, done_q, acc_q, taken_q, upd_q;
  logic [VLW-1:0]    idx_q, vl_q, cnt_q, dec_q, nvl_q;
  logic [MAX_VL-1:0] pred_q;
  logic [4:0]        sel_q, mode_q;
  logic [1:0]        bo_q;
  vbr_ctl_t          ctl;

  logic              el_skip, el_ok, el_cnt;
  logic              acc_nx, vfail, brk, last, fin;
  logic [VLW-1:0]    idx_inc, cnt_nx;
  logic [FW-1:0]     base;

  vbr_mode_dec u_dec (.mode_i(mode_q), .ctl_o(ctl));

  // base field group from the selector's top bits, element offset wraps
  assign base      = {sel_q[4:2], {(FW-3){1'b0}}};
  assign crf_idx_o = base + FW'(idx_q);

  vbr_elem_test u_test (
    .field_i  (crf_data_i),
    .bit_sel_i(sel_q[1:0]),
    .pred_i   (pred_q[idx_q[PIW-1:0]]),
    .sz_i     (ctl.sz),
    .subst_i  (ctl.subst),
    .bo_i     (bo_q),
    .skip_o   (el_skip),
    .ok_o     (el_ok),
    .counted_o(el_cnt)
  );

  always_comb begin
    idx_inc = idx_q + 1'b1;
    cnt_nx  = cnt_q + VLW'(el_cnt);
    if (el_skip)      acc_nx = acc_q;
    else if (ctl.all) acc_nx = acc_q & el_ok;
    else              acc_nx = acc_q | el_ok;
    vfail = ctl.vlset & ~el_skip & ~el_ok;
    brk   = ~el_skip & (ctl.all ? ~el_ok : el_ok);
    last  = (idx_inc == vl_q);
    fin   = vfail | brk | last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      taken_q <= 1'b0;
      upd_q   <= 1'b0;
      idx_q   <= '0;
      vl_q    <= '0;
      cnt_q   <= '0;
      dec_q   <= '0;
      nvl_q   <= '0;
      pred_q  <= '0;
      sel_q   <= '0;
      mode_q  <= '0;
      bo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          vl_q   <= vl_i;
          pred_q <= pred_i;
          sel_q  <= sel_i;
          bo_q   <= bo_i;
          mode_q <= mode_i;
          idx_q  <= '0;
          cnt_q  <= '0;
          dec_q  <= '0;
          upd_q  <= 1'b0;
          nvl_q  <= vl_i;
          acc_q  <= ~mode_i[3];
          if (vl_i == '0) begin
            done_q  <= 1'b1;
            taken_q <= ~mode_i[3];
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else begin
        acc_q <= acc_nx;
        cnt_q <= cnt_nx;
        idx_q <= idx_inc;
        if (fin) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          taken_q <= acc_nx;
          dec_q   <= cnt_nx;
        end
        if (vfail) begin
          upd_q <= 1'b1;
          nvl_q <= ctl.vli ? idx_inc : idx_q;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign taken_o     = taken_q;
  assign new_vl_o    = nvl_q;
  assign vl_update_o = upd_q;
  assign dec_count_o = dec_q;

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(taken_o) && $stable(dec_count_o)
                               && $stable(new_vl_o) && $stable(vl_update_o)));
  a_r12_busy_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(vl_q) && $stable(mode_q)));
  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < vl_q));
  a_r9_dec_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_count_o <= vl_q);
  a_r8_newvl_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_update_o |-> (new_vl_o <= vl_q));
endmodule

// File: tb/vbr_eval_tb_top.sv
`timescale 1ns/1ps
module vbr_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [63:0] pred = '0;
  logic [4:0]  sel = '0;
  logic [1:0]  bo = '0;
  logic [4:0]  mode = '0;
  logic [6:0]  crf_idx;
  logic [3:0]  crf_data;
  logic        done, taken, vl_upd;
  logic [6:0]  new_vl, dec_cnt;
  logic [3:0]  crf [128];
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign crf_data = crf[crf_idx];

  vbr_eval dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .pred_i(pred),
    .sel_i(sel), .bo_i(bo), .mode_i(mode), .crf_idx_o(crf_idx),
    .crf_data_i(crf_data), .done_o(done), .taken_o(taken), .new_vl_o(new_vl),
    .vl_update_o(vl_upd), .dec_count_o(dec_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int v, input logic [63:0] p, input logic [4:0] s,
                       input logic [1:0] b, input logic [4:0] m,
                       output int e_tk, output int e_cnt, output int e_nvl,
                       output int e_upd, output int e_cyc);
    bit vset, vli, sub, all, sz, acc, tbit, ok;
    int ex;
    vset = m[0];
    vli = vset & m[2];
    sub = ~vset & m[2];
    all = m[3];
    sz = m[4];
    acc = ~all; e_cnt = 0; e_nvl = v; e_upd = 0; ex = v - 1;
    for (int i = 0; i < v; i++) begin
      if (!p[i] && !sz) continue;
      tbit = p[i] ? crf[(int'(s[4:2]) * 16 + i) % 128][s[1:0]] : sub;
      ok = b[0] | (tbit == b[1]);
      if (p[i]) e_cnt++;
      acc = all ? (acc & ok) : (acc | ok);
      if (vset && !ok) begin
        e_upd = 1; e_nvl = vli ? i + 1 : i; ex = i; break;
      end
      if (all ? !ok : ok) begin ex = i; break; end
    end
    e_tk = acc;
    e_cyc = (v == 0) ? 1 : ex + 2;
  endtask

  task automatic run(input int v, input logic [63:0] p, input logic [4:0] s,
                     input logic [1:0] b, input logic [4:0] m, input bit poke);
    int e_tk, e_cnt, e_nvl, e_upd, e_cyc, cyc;
    model(v, p, s, b, m, e_tk, e_cnt, e_nvl, e_upd, e_cyc);
    vl = 7'(v); pred = p; sel = s; bo = b; mode = m; start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (poke && cyc == 3) begin
        vl = 7'd1; mode = ~m; start = 1'b1;  // R12 ignored mid-walk
      end
    end while (!done && cyc < 200);
    start = 1'b0;
    chk(cyc == e_cyc, "R5 latency", cyc, e_cyc);
    chk(taken == e_tk, "R3/R4 taken", taken, e_tk);
    chk(int'(dec_cnt) == e_cnt, "R9 dec_count", dec_cnt, e_cnt);
    chk(vl_upd == e_upd, "R8 vl_update", vl_upd, e_upd);
    chk(int'(new_vl) == e_nvl, "R8 new_vl", new_vl, e_nvl);
    @(negedge clk);
    chk(!done, "R11 done pulse", done, 0);
    chk(taken == e_tk && int'(dec_cnt) == e_cnt, "R11 hold", taken, e_tk);
  endtask

  initial begin
    #(190000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    int vls[4];
    logic [63:0] preds[3];
    logic [4:0] sels[2];
    seed = 12345;
    for (int i = 0; i < 128; i++) begin
      seed = seed * 1103515245 + 12345;
      crf[i] = 4'(seed >>> 16);
    end
    vls[0] = 0; vls[1] = 1; vls[2] = 5; vls[3] = 17;
    preds[0] = '1; preds[1] = '0; preds[2] = 64'hA5C3_96F0_0F69_3C5A;
    sels[0] = 5'd6; sels[1] = 5'd31;  // base 16 bit 2; base 112 bit 3, wraps (R1)
    repeat (3) @(negedge clk);
    chk(!done && !taken && !vl_upd && dec_cnt == 0, "R11 reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R6 R7 R10 R13: every mode word x option bits x lengths x masks x selectors
    for (int m = 0; m < 32; m++)
      for (int b = 0; b < 4; b++)
        for (int v = 0; v < 4; v++)
          for (int p = 0; p < 3; p++)
            for (int s = 0; s < 2; s++)
              run(vls[v], preds[p], sels[s], 2'(b), 5'(m), 1'b0);
    // R1: full length walk wrapping the condition file
    run(64, preds[2], 5'd30, 2'b10, 5'b10000, 1'b0);
    run(64, '1, 5'd29, 2'b00, 5'b01001, 1'b0);
    // R12: start during walk, ALL with forced pass runs all 17 elements
    run(17, '1, 5'd6, 2'b01, 5'b01000, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule